// File: doc/BRIEF.md
# Twelve-Level Masked Interrupt Entry Sequencer

This block decides when a processor core leaves its instruction stream to service an interrupt, and it carries out the entry into the service routine in hardware. Twelve request classes are numbered 0 to 11. A lower number has higher priority. Each class is gated by one enable bit of the program status word. Requests are looked at only when the core signals an instruction boundary, and only while a master enable is on. A request that is not taken simply stays pending at the requester.

When a class is accepted, the sequencer clears the master enable and reads a pointer word from a fixed memory location chosen by the class. For the data-channel and external classes, a device or group number indexes a table. The sequencer stores the interrupted program counter at the pointer address and the accumulator at the address after it. It then hands the core a new program counter equal to the pointer plus two. For three classes it also hands over a new accumulator value. `busy_o` holds off instruction fetch for the whole entry. The memory port is a plain single-port interface whose read data returns one cycle after the request.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset, `busy_o`, `mem_req_o`, `mem_we_o`, `pc_load_o` and `acc_load_o` are low, and the master enable is off.
- R2: Class k is eligible only when `req_i[k]` and `psw_i[k]` are both 1, `boundary_i` is high and the master enable is on. Bits 15..12 of `psw_i` (condition and precision flags) never cause an entry.
- R3: Among the eligible classes, the lowest-numbered one is entered.
- R4: After a `set_master_i` pulse, the first boundary that follows is not sampled. The second boundary is sampled, and the master enable stays on after it.
- R5: `clr_master_i` disables sampling at once, including a boundary in the same cycle, and cancels a set that has not yet taken effect.
- R6: Accepting an entry turns the master enable off. Later boundaries cause no entry until a new set takes effect.
- R7: The pointer is read from the following addresses: 490+k for classes 0..4, 485 for class 5 (timer), 486 for class 10 (alarm), 430+`chan_dev_i` for classes 6..9, and 356+`ext_group_i` for class 11.
- R8: The entry makes one read at the vector address. Two cycles later it writes the saved `pc_i` to the pointer address, and in the next cycle it writes the saved `acc_i` to the pointer address plus one.
- R9: In the cycle after the second write, `pc_load_o` pulses for one cycle with `pc_new_o` equal to the pointer plus two.
- R10: Together with `pc_load_o`, `acc_load_o` pulses with the following values: {8'h00, `trap_field_i`} for class 0, {12'h000, `timer_fired_i`} for class 5, and `ext_word_i` for class 11. No accumulator load happens for any other class.
- R11: At a boundary that starts no entry, if `req_i[0]` is 1 and `psw_i[0]` is 0, `acc_load_o` pulses one cycle later with {8'h00, `trap_field_i`}. This holds whatever the state of the master enable.
- R12: `busy_o` rises in the cycle after the accepting boundary and stays high for exactly 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 12 | Request level per class |
| psw_i | input | 16 | Status word; bit k enables class k |
| boundary_i | input | 1 | Instruction-boundary strobe |
| set_master_i | input | 1 | Delayed master-enable set command |
| clr_master_i | input | 1 | Immediate master-enable clear command |
| trap_field_i | input | 8 | Field of the trapping instruction |
| timer_fired_i | input | 4 | Bitmap of fired interval timers |
| ext_group_i | input | 6 | External group number |
| chan_dev_i | input | 6 | Data-channel device number |
| ext_word_i | input | 16 | Word supplied by the external device |
| pc_i | input | 16 | Current program counter |
| acc_i | input | 16 | Current accumulator |
| mem_rdata_i | input | 16 | Memory read data, one cycle after request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 15 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| pc_load_o | output | 1 | Load new program counter |
| pc_new_o | output | 16 | New program counter |
| acc_load_o | output | 1 | Load new accumulator |
| acc_new_o | output | 16 | New accumulator value |
| busy_o | output | 1 | Entry in progress; stall fetch |

## Verification
The assertions check on every cycle that entries start only at boundaries with an enabled request, and that a clear in the same cycle as a boundary blocks the entry. They also check that every entry opens with a read and that the second save address follows the first. Finally, they check that the new program counter lies one past the last saved address. The bench scenarios are needed to show the two-boundary delay after a set, the priority choice and vector address for each class, and the class-specific accumulator values. The same applies to the accumulator load of a masked trap.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CLS_TRAP   = 0;
  localparam int CLS_TIMER  = 5;
  localparam int CLS_CH_LO  = 6;
  localparam int CLS_CH_HI  = 9;
  localparam int CLS_ALARM  = 10;
  localparam int CLS_EXT    = 11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_SAVE_PC, ST_SAVE_ACC, ST_RESUME
  } entry_st_t;
endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 12,
  parameter int CW = 4
) (
  input  logic [N-1:0]  pend_i,
  output logic          hit_o,
  output logic [CW-1:0] cls_o
);
  logic [N-1:0] lower;
  logic [N-1:0] grant;

  assign lower[0] = 1'b0;
  for (genvar k = 1; k < N; k++) begin : g_chain
    assign lower[k] = lower[k-1] | pend_i[k-1];
  end

  assign grant = pend_i & ~lower;
  assign hit_o = |pend_i;

  always_comb begin
    cls_o = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) cls_o = CW'(i);
  end
endmodule

// File: rtl/irq_master.sv
module irq_master (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic boundary_i,
  input  logic busy_i,
  input  logic accept_i,
  output logic sample_ok_o
);
  logic       on_q;
  logic [1:0] delay_q;

  assign sample_ok_o = !clr_i && (on_q || delay_q == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= 1'b0;
      delay_q <= 2'd0;
    end else if (clr_i || accept_i) begin
      on_q    <= 1'b0;
      delay_q <= 2'd0;
    end else if (set_i) begin
      delay_q <= 2'd2;
    end else if (boundary_i && !busy_i && delay_q != 2'd0) begin
      delay_q <= delay_q - 2'd1;
      if (delay_q == 2'd1) on_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_pkg::*;
#(
  parameter int CW         = 4,
  parameter int AW         = 15,
  parameter int DW         = 16,
  parameter int GW         = 6,
  parameter int TW         = 8,
  parameter int NTMR       = 4,
  parameter int INT_BASE   = 490,
  parameter int TIMER_PTR  = 485,
  parameter int ALARM_PTR  = 486,
  parameter int CHAN_BASE  = 430,
  parameter int EXT_BASE   = 356
) (
  input  logic [CW-1:0]   cls_i,
  input  logic [GW-1:0]   group_i,
  input  logic [GW-1:0]   dev_i,
  input  logic [TW-1:0]   trap_i,
  input  logic [NTMR-1:0] timer_i,
  input  logic [DW-1:0]   ext_i,
  output logic [AW-1:0]   vec_o,
  output logic            acc_take_o,
  output logic [DW-1:0]   acc_val_o
);
  always_comb begin
    vec_o      = AW'(INT_BASE) + AW'(cls_i);
    acc_take_o = 1'b0;
    acc_val_o  = '0;
    if (cls_i == CW'(CLS_TRAP)) begin
      acc_take_o = 1'b1;
      acc_val_o  = DW'(trap_i);
    end else if (cls_i == CW'(CLS_TIMER)) begin
      vec_o      = AW'(TIMER_PTR);
      acc_take_o = 1'b1;
      acc_val_o  = DW'(timer_i);
    end else if (cls_i >= CW'(CLS_CH_LO) && cls_i <= CW'(CLS_CH_HI)) begin
      vec_o = AW'(CHAN_BASE) + AW'(dev_i);
    end else if (cls_i == CW'(CLS_ALARM)) begin
      vec_o = AW'(ALARM_PTR);
    end else if (cls_i == CW'(CLS_EXT)) begin
      vec_o      = AW'(EXT_BASE) + AW'(group_i);
      acc_take_o = 1'b1;
      acc_val_o  = ext_i;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int NCLS = 12,
  parameter int AW   = 15,
  parameter int DW   = 16,
  parameter int GW   = 6,
  parameter int TW   = 8,
  parameter int NTMR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] req_i,
  input  logic [DW-1:0]   psw_i,
  input  logic            boundary_i,
  input  logic            set_master_i,
  input  logic            clr_master_i,
  input  logic [TW-1:0]   trap_field_i,
  input  logic [NTMR-1:0] timer_fired_i,
  input  logic [GW-1:0]   ext_group_i,
  input  logic [GW-1:0]   chan_dev_i,
  input  logic [DW-1:0]   ext_word_i,
  input  logic [DW-1:0]   pc_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            pc_load_o,
  output logic [DW-1:0]   pc_new_o,
  output logic            acc_load_o,
  output logic [DW-1:0]   acc_new_o,
  output logic            busy_o
);
  localparam int CW = $clog2(NCLS);

  logic [NCLS-1:0] pend_m;
  logic            hit;
  logic [CW-1:0]   cls;
  logic            sample_ok;
  logic            accept;
  logic            trap_sink;
  logic [AW-1:0]   vec;
  logic            acc_take;
  logic [DW-1:0]   acc_val;

  entry_st_t       st;
  logic [AW-1:0]   ptr_q;
  logic [DW-1:0]   pc_sv, acc_sv, accv_q;
  logic            acct_q;

  assign pend_m    = req_i & psw_i[NCLS-1:0];
  assign accept    = boundary_i && !busy_o && sample_ok && hit;
  assign trap_sink = boundary_i && !busy_o && !accept &&
                     req_i[CLS_TRAP] && !psw_i[CLS_TRAP];

  irq_prio #(.N(NCLS), .CW(CW)) u_prio (
    .pend_i(pend_m), .hit_o(hit), .cls_o(cls)
  );

  irq_master u_master (
    .clk(clk), .rst(rst), .set_i(set_master_i), .clr_i(clr_master_i),
    .boundary_i(boundary_i), .busy_i(busy_o), .accept_i(accept),
    .sample_ok_o(sample_ok)
  );

  irq_vector #(.CW(CW), .AW(AW), .DW(DW), .GW(GW), .TW(TW), .NTMR(NTMR)) u_vec (
    .cls_i(cls), .group_i(ext_group_i), .dev_i(chan_dev_i),
    .trap_i(trap_field_i), .timer_i(timer_fired_i), .ext_i(ext_word_i),
    .vec_o(vec), .acc_take_o(acc_take), .acc_val_o(acc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      busy_o      <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      pc_load_o   <= 1'b0;
      pc_new_o    <= '0;
      acc_load_o  <= 1'b0;
      acc_new_o   <= '0;
      ptr_q       <= '0;
      pc_sv       <= '0;
      acc_sv      <= '0;
      accv_q      <= '0;
      acct_q      <= 1'b0;
    end else begin
      pc_load_o  <= 1'b0;
      acc_load_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st         <= ST_FETCH;
            busy_o     <= 1'b1;
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_addr_o <= vec;
            pc_sv      <= pc_i;
            acc_sv     <= acc_i;
            accv_q     <= acc_val;
            acct_q     <= acc_take;
          end else if (trap_sink) begin
            acc_load_o <= 1'b1;
            acc_new_o  <= DW'(trap_field_i);
          end
        end
        ST_FETCH: begin
          mem_req_o <= 1'b0;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          ptr_q       <= mem_rdata_i[AW-1:0];
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= mem_rdata_i[AW-1:0];
          mem_wdata_o <= pc_sv;
          st          <= ST_SAVE_PC;
        end
        ST_SAVE_PC: begin
          mem_addr_o  <= ptr_q + AW'(1);
          mem_wdata_o <= acc_sv;
          st          <= ST_SAVE_ACC;
        end
        ST_SAVE_ACC: begin
          mem_req_o  <= 1'b0;
          mem_we_o   <= 1'b0;
          pc_load_o  <= 1'b1;
          pc_new_o   <= DW'(ptr_q + AW'(2));
          acc_load_o <= acct_q;
          acc_new_o  <= accv_q;
          st         <= ST_RESUME;
        end
        ST_RESUME: begin
          busy_o <= 1'b0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int NCLS = 12,
  parameter int AW   = 15,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [NCLS-1:0] req_i,
  input logic [DW-1:0]   psw_i,
  input logic            boundary_i,
  input logic            clr_master_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            pc_load_o,
  input logic [DW-1:0]   pc_new_o,
  input logic            busy_o
);
  p_start_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(boundary_i) && ($past(req_i & psw_i[NCLS-1:0]) != '0));

  p_masked_no_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !busy_o && ((req_i & psw_i[NCLS-1:0]) == '0)) |=> !busy_o);

  p_clear_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && clr_master_i && !busy_o) |=> !busy_o);

  p_read_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> mem_req_o && !mem_we_o);

  p_acc_after_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(1));

  p_write_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o);

  p_resume_addr_r9: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> busy_o && pc_new_o[AW-1:0] == $past(mem_addr_o) + AW'(1));
endmodule

bind irq_entry_seq irq_entry_chk #(.NCLS(NCLS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .psw_i(psw_i), .boundary_i(boundary_i),
  .clr_master_i(clr_master_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o),
  .busy_o(busy_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] req_i = '0;
  logic [15:0] psw_i = '0;
  logic        boundary_i = 1'b0, set_master_i = 1'b0, clr_master_i = 1'b0;
  logic [7:0]  trap_field_i = '0;
  logic [3:0]  timer_fired_i = '0;
  logic [5:0]  ext_group_i = '0, chan_dev_i = '0;
  logic [15:0] ext_word_i = '0, pc_i = '0, acc_i = '0, mem_rdata_i = '0;
  logic        mem_req_o, mem_we_o, pc_load_o, acc_load_o, busy_o;
  logic [14:0] mem_addr_o;
  logic [15:0] mem_wdata_o, pc_new_o, acc_new_o;

  always #2.5 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (.*);

  int n_run = 0, n_fail = 0;
  logic [15:0] mem [1024];
  int rd_cnt, wr_cnt, pcl_cnt, accl_cnt, busy_cnt;
  logic [14:0] rd_addr, wa [2];
  logic [15:0] wd [2], pc_val, acc_val;

  always @(posedge clk) begin
    if (mem_req_o && !mem_we_o) begin
      mem_rdata_i <= mem[mem_addr_o[9:0]];
      rd_addr <= mem_addr_o; rd_cnt <= rd_cnt + 1;
    end
    if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[9:0]] <= mem_wdata_o;
      if (wr_cnt < 2) begin wa[wr_cnt] <= mem_addr_o; wd[wr_cnt] <= mem_wdata_o; end
      wr_cnt <= wr_cnt + 1;
    end
    if (pc_load_o) begin pcl_cnt <= pcl_cnt + 1; pc_val <= pc_new_o; end
    if (acc_load_o) begin accl_cnt <= accl_cnt + 1; acc_val <= acc_new_o; end
    if (busy_o) busy_cnt <= busy_cnt + 1;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; pcl_cnt = 0; accl_cnt = 0; busy_cnt = 0;
  endtask

  task automatic pulse_set();
    @(negedge clk); set_master_i = 1'b1;
    @(negedge clk); set_master_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_master_i = 1'b1;
    @(negedge clk); clr_master_i = 1'b0;
  endtask

  task automatic idle_boundary();
    logic [11:0] sv = req_i;
    @(negedge clk); req_i = '0; boundary_i = 1'b1;
    @(negedge clk); boundary_i = 1'b0; req_i = sv;
  endtask

  function automatic int exp_class(input logic [11:0] r, input logic [15:0] p);
    for (int i = 0; i < 12; i++) if (r[i] && p[i]) return i;
    return -1;
  endfunction

  function automatic logic [14:0] exp_vec(input int c);
    if (c <= 4) return 15'(490 + c);
    if (c == 5) return 15'd485;
    if (c <= 9) return 15'(430 + int'(chan_dev_i));
    if (c == 10) return 15'd486;
    return 15'(356 + int'(ext_group_i));
  endfunction

  // One boundary with the current inputs; master_on is the expected master state.
  task automatic boundary_check(input bit master_on, input clr_same);
    int c = master_on && !clr_same ? exp_class(req_i, psw_i) : -1;
    logic [14:0] v = '0;
    logic [15:0] ptr = '0;
    if (c >= 0) begin v = exp_vec(c); ptr = mem[v[9:0]]; end
    clear_log();
    boundary_i = 1'b1; clr_master_i = clr_same;
    @(negedge clk); boundary_i = 1'b0; clr_master_i = 1'b0;
    repeat (8) @(negedge clk);
    if (c >= 0) begin
      chk("R3 R7 read address", {rd_cnt[15:0], 1'b0, rd_addr}, {16'd1, 1'b0, v});
      chk("R8 pc save", {1'b0, wa[0], wd[0]}, {1'b0, ptr[14:0], pc_i});
      chk("R8 acc save", {wr_cnt[0], wa[1], wd[1]}, {1'b0, ptr[14:0] + 15'd1, acc_i});
      chk("R9 new pc", {pcl_cnt[15:0], pc_val}, {16'd1, 16'(ptr[14:0] + 15'd2)});
      chk("R12 busy length", busy_cnt, 5);
      if (c == 0 || c == 5 || c == 11)
        chk("R10 acc value", {accl_cnt[15:0], acc_val},
            {16'd1, c == 0 ? {8'h00, trap_field_i} : c == 5 ? {12'h000, timer_fired_i} : ext_word_i});
      else
        chk("R10 no acc load", accl_cnt, 0);
    end else begin
      chk("R2 R4 R5 R6 no entry", {rd_cnt[7:0], wr_cnt[7:0], pcl_cnt[7:0], busy_cnt[7:0]}, 0);
      if (req_i[0] && !psw_i[0])
        chk("R11 masked trap load", {accl_cnt[15:0], acc_val}, {16'd1, 8'h00, trap_field_i});
      else
        chk("R11 no acc load", accl_cnt, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd640));
    for (int i = 0; i < 1024; i++) mem[i] = 16'((i * 7 + 3) % 1000);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {busy_o, mem_req_o, mem_we_o, pc_load_o, acc_load_o}, 0);

    // R2: master off after reset, enabled request ignored
    req_i = 12'h010; psw_i = 16'h0FFF; pc_i = 16'h1234; acc_i = 16'h5678;
    boundary_check(1'b0, 1'b0);
    // R11: masked trap with master off still loads field
    req_i = 12'h001; psw_i = 16'h0FFE; trap_field_i = 8'hA5;
    boundary_check(1'b0, 1'b0);
    // R4: first boundary after set not sampled, second one sampled
    req_i = 12'h410; psw_i = 16'h0FFF;
    pulse_set();
    boundary_check(1'b0, 1'b0);
    boundary_check(1'b1, 1'b0);
    // R6: master off after entry
    boundary_check(1'b0, 1'b0);
    // R4: master stays on when second boundary takes nothing
    pulse_set(); idle_boundary(); idle_boundary();
    req_i = 12'h800; ext_group_i = 6'd9; ext_word_i = 16'hBEEF;
    boundary_check(1'b1, 1'b0);
    // R5: clear in the same cycle as boundary
    pulse_set(); idle_boundary();
    req_i = 12'h020; timer_fired_i = 4'b1010;
    boundary_check(1'b1, 1'b1);
    boundary_check(1'b0, 1'b0);
    // R5: clear cancels a pending set
    pulse_set(); pulse_clr(); idle_boundary();
    boundary_check(1'b0, 1'b0);
    // R2: flag bits alone never enter
    pulse_set(); idle_boundary();
    req_i = 12'h000; psw_i = 16'hF000;
    boundary_check(1'b1, 1'b0);
    pulse_clr();

    for (int it = 0; it < 200; it++) begin
      pulse_clr(); pulse_set(); idle_boundary();
      req_i = 12'($urandom) & 12'($urandom);
      psw_i = 16'($urandom);
      trap_field_i = 8'($urandom); timer_fired_i = 4'($urandom);
      ext_group_i = 6'($urandom); chan_dev_i = 6'($urandom);
      ext_word_i = 16'($urandom); pc_i = 16'($urandom); acc_i = 16'($urandom);
      boundary_check(1'b1, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule